// File: doc/BRIEF.md
# Bit-Group Shift, Rotate and Bit-Manipulation Unit

This purely combinational unit executes the second-byte operation group of an 8-bit processor's bit-manipulation instruction page. It receives the operation byte that follows the page prefix, the 8-bit operand fetched by the datapath and the current carry flag. In the same cycle it returns the result byte, a new flag byte, a flag write strobe and a register write strobe. It also returns the decoded operand selector, so the surrounding datapath can steer the operand from a register or from memory and write the result back to the same place.

The unit covers eight shift and rotate kinds. These include the left shift that fills bit 0 with a one, which fills the last free slot of the eight-entry shift table. It also covers single-bit test, clear and set on any of the eight bit positions. Memory access, fetch sequencing and the register file are not part of this block.

Top module: `cbu_unit`

## Requirements
- R1: Operation bits 7:6 pick the group: 00 shift/rotate, 01 bit test, 10 bit clear, 11 bit set. flag_we is 1 for groups 00 and 01 and 0 otherwise. reg_we is 1 for every group except 01.
- R2: In group 00, bits 5:3 pick the kind: 000 rotate left circular, 001 rotate right circular, 010 rotate left through carry, 011 rotate right through carry, 100 arithmetic left shift (0 enters bit 0), 101 arithmetic right shift (bit 7 kept), 111 logical right shift (0 enters bit 7). Left kinds put old bit 7 into carry and right kinds put old bit 0 into carry. The through-carry kinds move the incoming carry into the vacated bit.
- R3: Kind 110 (operation bytes 0x30 to 0x37) acts like the arithmetic left shift, except that a 1 enters bit 0. The carry takes old bit 7.
- R4: Flag byte layout, MSB to LSB: S, Z, Y, H, X, P/V, N, C. For group 00: S is result bit 7, Z is 1 when the result is zero, Y is result bit 5, X is result bit 3, P/V is 1 for an even count of ones, H is 0, N is 0 and C is the shifted-out carry.
- R5: For group 01, with n = bits 5:3: Z and P/V are both the inverse of operand bit n, H is 1, N is 0, C equals carry_i, S is 1 only when n is 7 and operand bit 7 is 1, and Y and X are operand bits 5 and 3. The result byte equals the operand, and nothing is stored (reg_we is 0).
- R6: Group 10 clears operand bit n and group 11 sets it. All other bits pass through unchanged. flag_we is 0 and the flag byte is 0x00.
- R7: sel_reg equals operation bits 2:0 (000 B, 001 C, 010 D, 011 E, 100 H, 101 L, 110 memory at HL, 111 A). sel_mem is 1 exactly when that field is 110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 8 | Operation byte following the page prefix |
| operand_i | input | 8 | Operand value |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 8 | Result byte |
| flags_o | output | 8 | New flag byte (S Z Y H X P/V N C) |
| flag_we_o | output | 1 | Flag byte is to be written |
| reg_we_o | output | 1 | Result is to be written to the selected operand |
| sel_reg_o | output | 3 | Decoded operand selector |
| sel_mem_o | output | 1 | Operand is the memory byte at HL |

## Verification
Every one of the 256 operation bytes is applied with every operand value and with both carry-in values. The carry-in pass separates the through-carry rotates from the circular rotates. It also shows that carry_i passes to C in the bit test and affects nothing else. All operands with a single bit set or cleared show whether test, clear and set act on the right position and leave the neighbouring bits alone. The operands 0x00, 0x80 and 0x01 together separate the one-filling left shift from the zero-filling one, and the sign-keeping right shift from the zero-filling one.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  localparam int DATA_W  = 8;
  localparam int FIELD_W = 3;
  localparam int LANES   = 1 << FIELD_W;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'b00,
    GRP_TEST  = 2'b01,
    GRP_CLR   = 2'b10,
    GRP_SETB  = 2'b11
  } grp_e;

  typedef enum logic [FIELD_W-1:0] {
    SK_RLC = 3'd0, SK_RRC = 3'd1, SK_RL  = 3'd2, SK_RR  = 3'd3,
    SK_SLA = 3'd4, SK_SRA = 3'd5, SK_SLL = 3'd6, SK_SRL = 3'd7
  } sk_e;

  localparam int FL_S = 7, FL_Z = 6, FL_Y = 5, FL_H = 4;
  localparam int FL_X = 3, FL_P = 2, FL_N = 1, FL_C = 0;

  function automatic logic even_par(input logic [DATA_W-1:0] v);
    return ~^v;
  endfunction

  // returns {carry_out, result}
  function automatic logic [DATA_W:0] shift_calc(input sk_e k,
                                                 input logic [DATA_W-1:0] v,
                                                 input logic cin);
    logic msb, lsb;
    msb = v[DATA_W-1];
    lsb = v[0];
    case (k)
      SK_RLC:  return {msb, v[DATA_W-2:0], msb};
      SK_RRC:  return {lsb, lsb, v[DATA_W-1:1]};
      SK_RL:   return {msb, v[DATA_W-2:0], cin};
      SK_RR:   return {lsb, cin, v[DATA_W-1:1]};
      SK_SLA:  return {msb, v[DATA_W-2:0], 1'b0};
      SK_SRA:  return {lsb, msb, v[DATA_W-1:1]};
      SK_SLL:  return {msb, v[DATA_W-2:0], 1'b1};
      default: return {lsb, 1'b0, v[DATA_W-1:1]};
    endcase
  endfunction
endpackage

// File: rtl/cbu_decode.sv
module cbu_decode
  import cbu_pkg::*;
(
  input  logic [7:0]         op,
  output grp_e               grp,
  output logic [FIELD_W-1:0] mid_field,
  output logic [FIELD_W-1:0] sel_reg,
  output logic               sel_mem,
  output logic               flag_we,
  output logic               reg_we
);
  localparam logic [FIELD_W-1:0] MEM_CODE = 3'b110;

  always_comb begin
    grp       = grp_e'(op[7:6]);
    mid_field = op[5:3];
    sel_reg   = op[2:0];
    sel_mem   = (op[2:0] == MEM_CODE);
    flag_we   = (grp == GRP_SHIFT) || (grp == GRP_TEST);
    reg_we    = (grp != GRP_TEST);
    // at least one strobe is always raised, and a test never stores
    assert_strobe_R1: assert (flag_we || reg_we);
    assert_test_nowrite_R1: assert (!(op[7:6] == 2'b01) || (flag_we && !reg_we));
  end
endmodule

// File: rtl/cbu_shifter.sv
module cbu_shifter
  import cbu_pkg::*;
(
  input  sk_e               kind,
  input  logic [DATA_W-1:0] value,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  logic is_left;

  always_comb begin
    {cout, res} = shift_calc(kind, value, cin);
    is_left     = ~kind[0];
    if (is_left) begin
      assert_left_carry_R2: assert (cout == value[DATA_W-1] && res[DATA_W-1:1] == value[DATA_W-2:0]);
    end else begin
      assert_right_carry_R2: assert (cout == value[0] && res[DATA_W-2:0] == value[DATA_W-1:1]);
    end
    if (kind == SK_SLL) begin
      assert_sll_fill_R3: assert (res[0] == 1'b1);
    end
  end
endmodule

// File: rtl/cbu_bitops.sv
module cbu_bitops
  import cbu_pkg::*;
(
  input  logic [FIELD_W-1:0] idx,
  input  logic [DATA_W-1:0]  value,
  input  logic               set_mode,
  output logic [DATA_W-1:0]  res,
  output logic               tested
);
  logic [DATA_W-1:0] lane_mask;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_mask[i] = (idx == FIELD_W'(i));
  end

  always_comb begin
    res    = set_mode ? (value | lane_mask) : (value & ~lane_mask);
    tested = |(value & lane_mask);
    assert_other_bits_R6: assert (((res ^ value) & ~lane_mask) == '0);
    assert_target_R6: assert ((|(res & lane_mask)) == set_mode);
  end
endmodule

// File: rtl/cbu_unit.sv
module cbu_unit
  import cbu_pkg::*;
(
  input  logic [7:0] op_i,
  input  logic [7:0] operand_i,
  input  logic       carry_i,
  output logic [7:0] result_o,
  output logic [7:0] flags_o,
  output logic       flag_we_o,
  output logic       reg_we_o,
  output logic [2:0] sel_reg_o,
  output logic       sel_mem_o
);
  grp_e               grp;
  logic [FIELD_W-1:0] mid_field;
  logic [DATA_W-1:0]  sh_res, bo_res;
  logic               sh_cout, bo_tested;

  cbu_decode i_dec (
    .op(op_i), .grp(grp), .mid_field(mid_field), .sel_reg(sel_reg_o),
    .sel_mem(sel_mem_o), .flag_we(flag_we_o), .reg_we(reg_we_o)
  );

  cbu_shifter i_sh (
    .kind(sk_e'(mid_field)), .value(operand_i), .cin(carry_i),
    .res(sh_res), .cout(sh_cout)
  );

  cbu_bitops i_bo (
    .idx(mid_field), .value(operand_i), .set_mode(grp == GRP_SETB),
    .res(bo_res), .tested(bo_tested)
  );

  always_comb begin
    result_o = operand_i;
    flags_o  = '0;
    case (grp)
      GRP_SHIFT: begin
        result_o      = sh_res;
        flags_o[FL_S] = sh_res[7];
        flags_o[FL_Z] = (sh_res == '0);
        flags_o[FL_Y] = sh_res[5];
        flags_o[FL_X] = sh_res[3];
        flags_o[FL_P] = even_par(sh_res);
        flags_o[FL_C] = sh_cout;
      end
      GRP_TEST: begin
        result_o      = operand_i;
        flags_o[FL_S] = (mid_field == 3'd7) && bo_tested;
        flags_o[FL_Z] = ~bo_tested;
        flags_o[FL_Y] = operand_i[5];
        flags_o[FL_H] = 1'b1;
        flags_o[FL_X] = operand_i[3];
        flags_o[FL_P] = ~bo_tested;
        flags_o[FL_C] = carry_i;
      end
      default: begin
        result_o = bo_res;
      end
    endcase
    if (grp == GRP_SHIFT) begin
      assert_zero_flag_R4: assert (flags_o[FL_Z] == (result_o == '0));
      assert_sign_flag_R4: assert (flags_o[FL_S] == result_o[7] && !flags_o[FL_H]);
    end
    if (grp == GRP_TEST) begin
      assert_test_passthru_R5: assert (result_o == operand_i && flags_o[FL_C] == carry_i);
    end
  end
endmodule

// File: tb/test_cbu_unit.sv
module test_cbu_unit;
  typedef struct packed {
    logic [7:0] op;
    logic [7:0] res;
    logic [7:0] flags;
    logic       fwe;
    logic       rwe;
    logic [2:0] sel;
    logic       mem;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] op_i = 8'h00, operand_i = 8'h00;
  logic       carry_i = 1'b0;
  logic [7:0] result_o, flags_o;
  logic       flag_we_o, reg_we_o, sel_mem_o;
  logic [2:0] sel_reg_o;

  int    n_checks = 0, n_fail = 0;
  bit    finished = 1'b0;
  item_t sb_q[$];

  always #10 clk = ~clk;

  cbu_unit i_cbu_unit (
    .op_i(op_i), .operand_i(operand_i), .carry_i(carry_i),
    .result_o(result_o), .flags_o(flags_o), .flag_we_o(flag_we_o),
    .reg_we_o(reg_we_o), .sel_reg_o(sel_reg_o), .sel_mem_o(sel_mem_o)
  );

  function automatic int ones(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += v[i];
    return n;
  endfunction

  function automatic item_t model(input logic [7:0] op, input logic [7:0] v, input logic c);
    item_t e;
    logic [2:0] k;
    logic fill, cy;
    logic [7:0] r;
    k = op[5:3];
    e = '0;
    e.op  = op;
    e.sel = op[2:0];
    e.mem = (op[2:0] == 3'd6);
    e.fwe = (op[7:6] <= 2'd1);
    e.rwe = (op[7:6] != 2'd1);
    if (op[7:6] == 2'd0) begin
      if (k[0] == 1'b0) begin
        case (k)
          3'd0: fill = v[7];
          3'd2: fill = c;
          3'd6: fill = 1'b1;
          default: fill = 1'b0;
        endcase
        r  = {v[6:0], fill};
        cy = v[7];
      end else begin
        case (k)
          3'd1: fill = v[0];
          3'd3: fill = c;
          3'd5: fill = v[7];
          default: fill = 1'b0;
        endcase
        r  = {fill, v[7:1]};
        cy = v[0];
      end
      e.res   = r;
      e.flags = {r[7], r == 8'h00, r[5], 1'b0, r[3], (ones(r) % 2) == 0, 1'b0, cy};
    end else if (op[7:6] == 2'd1) begin
      e.res   = v;
      e.flags = {k == 3'd7 && v[7], !v[k], v[5], 1'b1, v[3], !v[k], 1'b0, c};
    end else begin
      r = v;
      r[k] = (op[7:6] == 2'd3);
      e.res   = r;
      e.flags = 8'h00;
    end
    return e;
  endfunction

  task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] op, input logic [7:0] v, input logic c);
    @(posedge clk);
    #1;
    op_i = op; operand_i = v; carry_i = c;
    sb_q.push_back(model(op, v, c));
  endtask

  // monitor: each driven vector is settled by the following falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() != 0) begin
        item_t e;
        string tres, tfl;
        e = sb_q.pop_front();
        case (e.op[7:6])
          2'd0: begin tres = (e.op[5:3] == 3'd6) ? "R3" : "R2"; tfl = "R4"; end
          2'd1: begin tres = "R5"; tfl = "R5"; end
          default: begin tres = "R6"; tfl = "R6"; end
        endcase
        check(tres, $sformatf("result op=%h", e.op), {8'h00, result_o}, {8'h00, e.res});
        check(tfl, $sformatf("flags op=%h", e.op), {8'h00, flags_o}, {8'h00, e.flags});
        check("R1", $sformatf("strobes op=%h", e.op), {14'h0, flag_we_o, reg_we_o}, {14'h0, e.fwe, e.rwe});
        check("R7", $sformatf("selector op=%h", e.op), {12'h0, sel_mem_o, sel_reg_o}, {12'h0, e.mem, e.sel});
      end
    end
  end

  initial begin
    #(190000 * 20);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // idle inputs: op 0x00 on operand 0 gives zero result, Z and P/V set
    check("R4", "idle result", {8'h00, result_o}, 16'h0000);
    check("R4", "idle flags", {8'h00, flags_o}, 16'h0044);
    check("R1", "idle strobes", {14'h0, flag_we_o, reg_we_o}, 16'h0003);
    // directed corner cases for the one-filling left shift
    drive(8'h30, 8'h80, 1'b0);   // R3: 0x80 -> 0x01, carry out 1
    drive(8'h37, 8'h00, 1'b1);   // R3: 0x00 -> 0x01
    drive(8'h20, 8'h80, 1'b0);   // R2: zero-fill 0x80 -> 0x00
    drive(8'h28, 8'h80, 1'b0);   // R2: sign-keeping 0x80 -> 0xC0
    drive(8'h38, 8'h80, 1'b0);   // R2: zero-fill right 0x80 -> 0x40
    drive(8'h7E, 8'h80, 1'b0);   // R5: test bit 7 set, S set
    drive(8'h86, 8'hFF, 1'b1);   // R6: clear bit 0 of memory operand
    drive(8'hFF, 8'h00, 1'b0);   // R6: set bit 7 of A
    // full sweep
    for (int c = 0; c < 2; c++)
      for (int op = 0; op < 256; op++)
        for (int v = 0; v < 256; v++)
          drive(8'(op), 8'(v), 1'(c));
    repeat (3) @(posedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule